// File: doc/BRIEF.md
# Bus Read-Data Pattern Toggle Detector

This block sits beside a bus master and watches its read-data lines. Whenever the lines begin to carry a fixed magic word, the single output bit flips. Software that reads that word at a steady rate therefore produces a square wave on the output. The output can drive an LED as a heartbeat that shows a program is still running.

The magic word is a parameter, 32'hF0F0F0F0 by default. An optional valid qualifier restricts matching to the cycles in which the bus is actually carrying read data. A word that stays on the bus for several cycles counts as a single event, so one read gives exactly one flip however long the slave holds the data. There is no register interface. The output comes straight from a flop.

Top module: `pattern_beacon`

## Requirements
- R1: An active-low asynchronous reset drives `beacon` to 0 at once and holds it there while reset is low.
- R2: `beacon` inverts on the clock edge that samples the first cycle of a qualified match, where a match means all DATA_W bits of `bus_data` equal MATCH (default 32'hF0F0F0F0).
- R3: `beacon` keeps its old value until that edge, and takes the new value in the cycle right after the one in which the pattern appears.
- R4: A match that stays present over consecutive qualified cycles inverts `beacon` only once. It must be absent for at least one sampled cycle before it can invert `beacon` again.
- R5: A bus value that differs from MATCH in any bit, including a single bit, leaves `beacon` unchanged.
- R6: With USE_VALID=1, a cycle in which `bus_valid` is 0 never inverts `beacon`, whatever `bus_data` holds. That cycle counts as an absent match, so a qualified match that follows it inverts `beacon` again.
- R7: With USE_VALID=0, `bus_valid` has no effect, and a match inverts `beacon` even while `bus_valid` is 0.
- R8: A match that is present on the first sampled cycle after reset is released counts as a new match and inverts `beacon`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_data | input | DATA_W | Monitored read-data value |
| bus_valid | input | 1 | Qualifier: bus_data is meaningful this cycle (used when USE_VALID=1) |
| beacon | output | 1 | Registered bit that inverts on each new match |

## Verification
The bench builds two copies of the block. The first uses the defaults (32'hF0F0F0F0, qualifier enabled). It is driven with held patterns, single-bit near misses, the inverted pattern, and qualifier-low cycles that both block a match and rearm one. The second copy uses a different match word with the qualifier disabled. This shows that the word is not fixed in the logic and that `bus_valid` is ignored in that variant. Directed cases cover a reset asserted while `beacon` is high, and a pattern already on the bus when reset is released.

// File: rtl/pattern_beacon.sv
module pattern_beacon #(
  parameter int              DATA_W    = 32,
  parameter logic [DATA_W-1:0] MATCH   = 32'hF0F0_F0F0,
  parameter bit              USE_VALID = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              bus_valid,
  output logic              beacon
);

  localparam logic ALWAYS_QUAL = !USE_VALID;

  logic hit;
  logic hit_q;

  assign hit = (bus_valid | ALWAYS_QUAL) & (bus_data == MATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hit_q  <= 1'b0;
      beacon <= 1'b0;
    end else begin
      hit_q <= hit;
      if (hit && !hit_q) beacon <= ~beacon;
    end
  end

endmodule

// File: rtl/pattern_beacon_chk.sv
module pattern_beacon_chk #(
  parameter int              DATA_W    = 32,
  parameter logic [DATA_W-1:0] MATCH   = 32'hF0F0_F0F0,
  parameter bit              USE_VALID = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] bus_data,
  input logic              bus_valid,
  input logic              beacon
);

  logic q;
  logic q_d;

  assign q = (bus_valid || !USE_VALID) && (bus_data == MATCH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_d <= 1'b0;
    else        q_d <= q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) AST_RESET_CLEAR: assert (beacon == 1'b0); // R1
  end

  AST_NEW_MATCH_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (q && !q_d) |=> (beacon != $past(beacon))); // R2

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(q && !q_d) |=> $stable(beacon)); // R4

  AST_HELD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (q && q_d) |=> $stable(beacon)); // R4

  AST_MISS_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_data != MATCH) |=> $stable(beacon)); // R5

  AST_INVALID_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (USE_VALID && !bus_valid) |=> $stable(beacon)); // R6

endmodule

bind pattern_beacon pattern_beacon_chk #(
  .DATA_W(DATA_W), .MATCH(MATCH), .USE_VALID(USE_VALID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_data(bus_data),
  .bus_valid(bus_valid), .beacon(beacon)
);

// File: tb/pattern_beacon_tb.sv
module pattern_beacon_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] data = '0;
  logic        valid = 1'b0;
  logic        beacon;
  logic [31:0] data_nv = '0;
  logic        valid_nv = 1'b0;
  logic        beacon_nv;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  pattern_beacon u_dut (
    .clk(clk), .rst_n(rst_n), .bus_data(data), .bus_valid(valid), .beacon(beacon)
  );

  pattern_beacon #(.DATA_W(32), .MATCH(32'h0000_A5A5), .USE_VALID(1'b0)) u_dut_nv (
    .clk(clk), .rst_n(rst_n), .bus_data(data_nv), .bus_valid(valid_nv), .beacon(beacon_nv)
  );

  // {valid, data, expected beacon after the edge}
  localparam logic [33:0] VEC [0:11] = '{
    {1'b1, 32'hF0F0_F0F0, 1'b1},  // R2 first match
    {1'b1, 32'hF0F0_F0F0, 1'b1},  // R4 held
    {1'b1, 32'h0000_0000, 1'b1},  // R5
    {1'b1, 32'hF0F0_F0F0, 1'b0},  // R2 second match
    {1'b0, 32'hF0F0_F0F0, 1'b0},  // R6 invalid ignored
    {1'b1, 32'hF0F0_F0F0, 1'b1},  // R6 rearmed by invalid cycle
    {1'b1, 32'hF0F0_F0F1, 1'b1},  // R5 one bit off
    {1'b1, 32'h70F0_F0F0, 1'b1},  // R5 top bit off
    {1'b1, 32'hF0F0_F0F0, 1'b0},  // R2
    {1'b1, 32'h0F0F_0F0F, 1'b0},  // R5 inverse pattern
    {1'b1, 32'hF0F0_F0F0, 1'b1},  // R2
    {1'b1, 32'hFFFF_FFFF, 1'b1}   // R5
  };

  task automatic check(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: beacon=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] d);
    @(negedge clk);
    valid = v;
    data  = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1;
    check("R1", beacon, 1'b0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1", beacon, 1'b0);

    for (int i = 0; i < 12; i++) begin
      step(VEC[i][33], VEC[i][32:1]);
      check($sformatf("R2/R4/R5/R6 vec %0d", i), beacon, VEC[i][0]);
    end

    // R3: beacon is 1 after the table; clear the bus, then watch the edge
    step(1'b1, 32'h1234_5678);
    @(negedge clk);
    valid = 1'b1;
    data  = 32'hF0F0_F0F0;
    #1;
    check("R3 before edge", beacon, 1'b1);
    @(posedge clk);
    #1;
    check("R3 after edge", beacon, 1'b0);

    // R1 asynchronous reset while beacon is high; R8 match held across release
    step(1'b1, 32'h0);
    step(1'b1, 32'hF0F0_F0F0);
    check("R2", beacon, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async", beacon, 1'b0);
    @(posedge clk);
    #1;
    check("R1 held", beacon, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R8", beacon, 1'b1);
    step(1'b1, 32'hF0F0_F0F0);
    check("R8/R4 held", beacon, 1'b1);

    // R7: qualifier disabled on second instance
    @(negedge clk);
    valid_nv = 1'b0;
    data_nv  = 32'h0000_A5A5;
    @(posedge clk);
    #1;
    check("R7 match with valid low", beacon_nv, 1'b1);
    @(negedge clk);
    data_nv = 32'hF0F0_F0F0;
    @(posedge clk);
    #1;
    check("R7/R5 default word not matched", beacon_nv, 1'b1);
    @(negedge clk);
    valid_nv = 1'b1;
    data_nv  = 32'h0000_A5A5;
    @(posedge clk);
    #1;
    check("R7 valid high", beacon_nv, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule